// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is a single programmable logic cell. Its behaviour is set by a small bank of configuration words, loaded through a write port before the cell is used. Every word describes one product term. A term is an AND over any chosen mix of true and complemented literals, taken from the external inputs and from one feedback signal. Eight such terms are ORed together. The OR result can be inverted and then either drives the pin directly or passes through a storage element first.

Three more terms act as controls:

- One clears the storage element asynchronously.
- One can clock the storage element in place of the global clock.
- One drives the pin's output enable.

A mode word sets the remaining options:

- the storage element acts as a D or T flip-flop;
- which edge of the global clock is active;
- whether the global clock or the clock term is used;
- whether the pin output is registered or combinational;
- whether the feedback literal is the flip-flop value or the pad value;
- whether the output enable is forced on.

The pad is modelled as separate value, enable and pad-input signals.

Top module: `pt_macrocell`

## Requirements
- R1: A write with cfg_we_i high at a rising clk_i edge stores cfg_wdata_i in the word at cfg_addr_i. Addresses 0 to 7 are the sum terms, 8 the clear term, 9 the clock term, 10 the output-enable term and 11 the mode word. Writes to addresses 12 and above change nothing. Reset makes every word zero, which gives pin_o = 0 and pin_oe_o = 0.
- R2: Term word bits [2j+1:2j] select literal j. The codes are 00 = not used, 01 = true, 10 = complemented, 11 = term forced to 0. Literals 0 to 3 are in_i[0..3] and literal 4 is the feedback signal.
- R3: A term with no literal in use evaluates to 0. The sum is the OR of the eight sum terms.
- R4: Mode bit 0 set inverts the sum to form the data value d.
- R5: With mode bit 4 set, pin_o equals d with no clock delay. With it clear, pin_o is the flip-flop output, which changes only on its clock.
- R6: With mode bit 1 clear, the flip-flop loads d on its active edge. With it set, the flip-flop toggles on an active edge when d = 1.
- R7: With mode bit 3 clear, the active edge is the rising clk_i edge when mode bit 2 is clear, and the falling clk_i edge when it is set.
- R8: With mode bit 3 set, the flip-flop is clocked by the rising edge of the clock term, and clk_i has no effect on it.
- R9: While the clear term is 1 the flip-flop is 0, and clock edges are blocked. rst_ni low also clears it.
- R10: pin_oe_o is the output-enable term ORed with mode bit 6.
- R11: The feedback literal is pin_i when mode bit 5 is set, and the flip-flop value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 10 | Configuration write data |
| in_i | input | 4 | External array inputs |
| pin_i | input | 1 | Value seen at the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe_o | output | 1 | Pad driver enable |

## Verification
The bench uses the defaults N_IN = 4 and N_SUM = 8. This gives five literals, a 10-bit term word and sixteen input patterns, so the combinational phases sweep every input combination exhaustively. The small literal count also lets a single term be set to each of the four literal codes, and lets pad feedback be forced independently of the flip-flop. All three clock sources are reached in one run, because the phases are ordered so that no change of clock source can create a stray edge.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int MODE_W = 7;

  // field order fixes mode word bit positions (bit 0 = invert)
  typedef struct packed {
    logic oe_on;
    logic fb_pin;
    logic comb_out;
    logic async_clk;
    logic fall_edge;
    logic t_type;
    logic invert;
  } mode_t;

  localparam int M_INV   = 0;
  localparam int M_TT    = 1;
  localparam int M_FALL  = 2;
  localparam int M_ASYNC = 3;
  localparam int M_OEON  = 6;
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pt_pkg::*;
#(
  parameter int N_TERM = 11,
  parameter int TERM_W = 10,
  parameter int ADDR_W = 4,
  parameter int CFG_W  = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CFG_W-1:0]              wdata_i,
  output logic [N_TERM-1:0][TERM_W-1:0] term_cfg_o,
  output mode_t                         mode_o
);
  for (genvar g = 0; g < N_TERM; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        term_cfg_o[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))
        term_cfg_o[g] <= wdata_i[TERM_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mode_o <= '0;
    else if (we_i && addr_i == ADDR_W'(N_TERM))
      mode_o <= mode_t'(wdata_i[MODE_W-1:0]);
  end
endmodule

// File: rtl/pt_term.sv
module pt_term #(
  parameter int N_LIT = 5
) (
  input  logic [2*N_LIT-1:0] cfg_i,
  input  logic [N_LIT-1:0]   lit_i,
  output logic               hit_o
);
  logic any_use, all_ok;

  always_comb begin
    any_use = 1'b0;
    all_ok  = 1'b1;
    for (int j = 0; j < N_LIT; j++) begin
      if (cfg_i[2*j]) begin
        any_use = 1'b1;
        if (!lit_i[j]) all_ok = 1'b0;
      end
      if (cfg_i[2*j+1]) begin
        any_use = 1'b1;
        if (lit_i[j]) all_ok = 1'b0;
      end
    end
  end

  // empty term must not force the OR high
  assign hit_o = any_use & all_ok;
endmodule

// File: rtl/pt_storage.sv
module pt_storage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic fall_i,
  input  logic t_type_i,
  input  logic clk_pt_i,
  input  logic clr_pt_i,
  input  logic d_i,
  output logic q_o
);
  logic ff_clk, arst;

  assign ff_clk = async_i ? clk_pt_i : (clk_i ^ fall_i);
  assign arst   = !rst_ni || clr_pt_i;

  always_ff @(posedge ff_clk or posedge arst) begin
    if (arst)
      q_o <= 1'b0;
    else
      q_o <= t_type_i ? (q_o ^ d_i) : d_i;
  end
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
  import pt_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_SUM = 8,
  localparam int N_LIT  = N_IN + 1,
  localparam int TERM_W = 2 * N_LIT,
  localparam int N_TERM = N_SUM + 3,
  localparam int N_WORD = N_TERM + 1,
  localparam int ADDR_W = $clog2(N_WORD),
  localparam int CFG_W  = (TERM_W > MODE_W) ? TERM_W : MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  localparam int T_CLR = N_SUM;
  localparam int T_CLK = N_SUM + 1;
  localparam int T_OE  = N_SUM + 2;

  logic [N_TERM-1:0][TERM_W-1:0] term_cfg;
  mode_t                         mode;
  logic [N_TERM-1:0]             hit;
  logic [N_LIT-1:0]              lits;
  logic                          fb, sum, d, q, clr;

  pt_cfg_regs #(
    .N_TERM(N_TERM), .TERM_W(TERM_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .term_cfg_o (term_cfg),
    .mode_o     (mode)
  );

  assign fb   = mode.fb_pin ? pin_i : q;
  assign lits = {fb, in_i};

  for (genvar g = 0; g < N_TERM; g++) begin : g_term
    pt_term #(.N_LIT(N_LIT)) u_term (
      .cfg_i (term_cfg[g]),
      .lit_i (lits),
      .hit_o (hit[g])
    );
  end

  assign sum = |hit[N_SUM-1:0];
  assign d   = sum ^ mode.invert;
  assign clr = hit[T_CLR];

  pt_storage u_ff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_i  (mode.async_clk),
    .fall_i   (mode.fall_edge),
    .t_type_i (mode.t_type),
    .clk_pt_i (hit[T_CLK]),
    .clr_pt_i (clr),
    .d_i      (d),
    .q_o      (q)
  );

  assign pin_o    = mode.comb_out ? d : q;
  assign pin_oe_o = hit[T_OE] | mode.oe_on;
endmodule

// File: rtl/pt_macrocell_chk.sv
module pt_macrocell_chk
  import pt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CFG_W     = 10,
  parameter int MODE_ADDR = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              q_i,
  input logic              d_i,
  input logic              clr_i,
  input logic              pin_oe_i
);
  logic rise_sync;
  assign rise_sync = !mode_i[M_ASYNC] && !mode_i[M_FALL] && !cfg_we_i && !clr_i;

  p_cfg_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(MODE_ADDR)) |=> mode_i == $past(cfg_wdata_i[MODE_W-1:0]));

  p_d_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_sync && !mode_i[M_TT]) |=> (q_i == $past(d_i)) || clr_i);

  p_t_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_sync && mode_i[M_TT]) |=> (q_i == $past(q_i ^ d_i)) || clr_i);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_i);

  p_oe_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[M_OEON] |-> pin_oe_i);
endmodule

bind pt_macrocell pt_macrocell_chk #(
  .ADDR_W(ADDR_W), .CFG_W(CFG_W), .MODE_ADDR(N_TERM)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .mode_i      (mode),
  .q_i         (q),
  .d_i         (d),
  .clr_i       (clr),
  .pin_oe_i    (pin_oe_o)
);

// File: tb/sim_pt_macrocell.sv
`timescale 1ns/1ps
module sim_pt_macrocell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  logic [3:0] in_v = '0;
  logic       pin_in = 1'b0;
  wire        pin_o, pin_oe;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pt_macrocell u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .in_i(in_v), .pin_i(pin_in),
    .pin_o(pin_o), .pin_oe_o(pin_oe)
  );

  // ---------------- reference model ----------------
  logic [9:0] cfg_m [12];
  logic       q_m = 1'b0;
  logic       sum_m, d_m, clr_m, ck_m, oe_m, exp_pin;
  logic [4:0] lit_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 12; k++) cfg_m[k] <= '0;
    end else if (cfg_we && cfg_addr < 4'd12) begin
      cfg_m[cfg_addr] <= cfg_wdata;
    end
  end

  function automatic logic term_m(input logic [9:0] w, input logic [4:0] l);
    int used = 0;
    bit ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      case (w[2*k +: 2])
        2'b01: begin used++; if (!l[k]) ok = 1'b0; end
        2'b10: begin used++; if (l[k]) ok = 1'b0; end
        2'b11: begin used++; ok = 1'b0; end
        default: ;
      endcase
    end
    return (used > 0) && ok;
  endfunction

  always_comb begin
    lit_m = {(cfg_m[11][5] ? pin_in : q_m), in_v};
    sum_m = 1'b0;
    for (int k = 0; k < 8; k++) if (term_m(cfg_m[k], lit_m)) sum_m = 1'b1;
    d_m     = sum_m ^ cfg_m[11][0];
    clr_m   = term_m(cfg_m[8], lit_m);
    ck_m    = term_m(cfg_m[9], lit_m);
    oe_m    = term_m(cfg_m[10], lit_m) | cfg_m[11][6];
    exp_pin = cfg_m[11][4] ? d_m : q_m;
  end

  always @(posedge clk)
    if (rst_n && !clr_m && !cfg_m[11][3] && !cfg_m[11][2])
      q_m <= cfg_m[11][1] ? (q_m ^ d_m) : d_m;
  always @(negedge clk)
    if (rst_n && !clr_m && !cfg_m[11][3] && cfg_m[11][2])
      q_m <= cfg_m[11][1] ? (q_m ^ d_m) : d_m;
  always @(posedge ck_m)
    if (rst_n && !clr_m && cfg_m[11][3])
      q_m <= cfg_m[11][1] ? (q_m ^ d_m) : d_m;
  always @(negedge rst_n or posedge clr_m)
    q_m <= 1'b0;

  // ---------------- checking ----------------
  task automatic chk(input string t, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1.25;
    if (checking && rst_n && !done) begin
      chk({tag, " pin_o"}, pin_o, exp_pin);
      chk({tag, " pin_oe_o"}, pin_oe, oe_m);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic [3:0] v, input logic p);
    @(negedge clk); #1.25;
    in_v = v;
    pin_in = p;
  endtask

  task automatic settle();
    @(posedge clk); #1.25;
  endtask

  task automatic wr(input logic [3:0] a, input logic [9:0] w);
    @(negedge clk); #1.25;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    @(negedge clk); #1.25;
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r = $urandom;
      drive(r[3:0], r[4]);
    end
  endtask

  task automatic sweep();
    for (int v = 0; v < 16; v++) begin
      logic [31:0] r = $urandom;
      drive(v[3:0], r[0]);
    end
  endtask

  // one signal group changes per step: data inputs or the clock input
  task automatic run_async(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r = $urandom;
      if (i % 2 == 0) drive({in_v[3], r[2:0]}, r[4]);
      else            drive({~in_v[3], in_v[2:0]}, pin_in);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1.25;
    chk("R1 reset pin_o", pin_o, 1'b0);
    chk("R1 reset pin_oe_o", pin_oe, 1'b0);
    @(negedge clk); #1.25;
    rst_n = 1'b1;
    checking = 1'b1;

    // R1: out-of-range writes ignored
    tag = "R1";
    wr(4'd12, 10'h3FF);
    wr(4'd15, 10'h3FF);
    run(6);
    settle();
    chk("R1 ignored write pin_oe_o", pin_oe, 1'b0);

    // R2: literal codes, comb output, oe forced
    tag = "R2";
    wr(4'd11, 10'h050);
    wr(4'd0, 10'h009);   // in0 & ~in1
    wr(4'd1, 10'h030);   // in2 code 11: always 0
    drive(4'b0001, 1'b0); settle(); chk("R2 true/compl hit", pin_o, 1'b1);
    drive(4'b0011, 1'b0); settle(); chk("R2 compl literal blocks", pin_o, 1'b0);
    drive(4'b0100, 1'b0); settle(); chk("R2 code 11 term zero", pin_o, 1'b0);
    sweep();

    // R3: OR of terms, empty terms are 0
    tag = "R3";
    wr(4'd3, 10'h040);   // in3
    drive(4'b1000, 1'b0); settle(); chk("R3 second term ORed", pin_o, 1'b1);
    drive(4'b0000, 1'b0); settle(); chk("R3 empty terms zero", pin_o, 1'b0);
    sweep();

    // R4: inversion
    tag = "R4";
    wr(4'd11, 10'h051);
    drive(4'b0000, 1'b0); settle(); chk("R4 inverted sum", pin_o, 1'b1);
    sweep();

    // R10: output enable term
    tag = "R10";
    wr(4'd11, 10'h010);
    wr(4'd10, 10'h001);  // oe on in0
    drive(4'b0000, 1'b0); settle(); chk("R10 oe term low", pin_oe, 1'b0);
    drive(4'b0001, 1'b0); settle(); chk("R10 oe term high", pin_oe, 1'b1);
    sweep();

    // R5: registered output waits for edge
    tag = "R5";
    wr(4'd11, 10'h040);
    drive(4'b0000, 1'b0);
    drive(4'b0000, 1'b0);
    drive(4'b0001, 1'b0);
    #0.5;
    chk("R5 no change before edge", pin_o, 1'b0);
    settle();
    chk("R5 loaded at edge", pin_o, 1'b1);
    run(20);

    // R6: D then T
    tag = "R6";
    run(20);
    wr(4'd11, 10'h042);
    run(30);

    // R11: feedback from flop, then from pad
    tag = "R11";
    wr(4'd4, 10'h100);   // feedback true
    wr(4'd11, 10'h040);
    run(20);
    wr(4'd11, 10'h060);
    run(30);

    // R9: clear term on in2
    tag = "R9";
    wr(4'd11, 10'h040);
    wr(4'd8, 10'h010);
    drive(4'b0001, 1'b0); settle();
    chk("R9 set before clear", pin_o, 1'b1);
    drive(4'b0101, 1'b0);
    #0.5;
    chk("R9 async clear", pin_o, 1'b0);
    run(30);

    // R7: falling edge
    tag = "R7";
    wr(4'd11, 10'h044);
    run(30);

    // R8: clock from term on in3
    tag = "R8";
    wr(4'd3, 10'h000);
    wr(4'd9, 10'h040);
    drive({1'b0, in_v[2:0]}, 1'b0);
    wr(4'd11, 10'h048);
    drive(4'b0100, 1'b0);
    drive(4'b0000, 1'b0);
    drive(4'b1000, 1'b0); settle();
    chk("R8 term edge loads 0", pin_o, 1'b0);
    drive(4'b1001, 1'b0);
    repeat (3) settle();
    chk("R8 clk_i ignored", pin_o, 1'b0);
    drive(4'b0001, 1'b0);
    drive(4'b1001, 1'b0); settle();
    chk("R8 term edge loads 1", pin_o, 1'b1);
    run_async(60);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule